// File: doc/BRIEF.md
# Strided Vector Load/Store Sequencer

This block turns one 256-bit SIMD strided memory instruction into a series of single-element memory accesses. A command gives a scalar base byte address, a stride counted in elements, an element-size flag and a direction flag. Register lane i is paired with the memory element that lies i strides past the base. The block walks the lanes from lowest to highest and issues one request per lane to a simple valid/ready memory port.

For a store, each request carries the matching slice of the 256-bit source vector. For a load, the in-order responses are collected in a staging buffer. The destination vector is published in one step when the last lane arrives. A stride outside the legal window is rejected at once, with no memory traffic. The block takes one command at a time.

Control is a five-state machine. `ST_IDLE` accepts a command and goes to `ST_ISSUE` on a legal stride, or to `ST_REJECT` on an illegal one. `ST_ISSUE` sends one request per ready cycle. After the last accepted request it goes to `ST_FIN` for a store, or to `ST_DRAIN` for a load. `ST_DRAIN` waits for the remaining responses and goes to `ST_FIN` on the last one. `ST_FIN` (completion pulse) and `ST_REJECT` (illegal pulse) both return to `ST_IDLE` after one cycle.

Top module: `stride_seq`

## Requirements
- R1: After reset, cmd_ready is 1, mem_req_valid, done and illegal are 0, and result_data is all zeros.
- R2: A command with a stride below 2 or above 7 produces a one-cycle illegal pulse in the cycle after acceptance. It issues no memory request, and cmd_ready returns to 1 in the cycle after the pulse.
- R3: A command with cmd_wide=1 (64-bit elements) issues exactly 4 requests. A command with cmd_wide=0 (32-bit elements) issues exactly 8. mem_req_wide repeats the latched element size.
- R4: Request k carries byte address base + k × stride × B, where B is 8 for wide and 4 for narrow, modulo 2^ADDR_W. Requests go out in increasing k, and the first request appears in the cycle after acceptance.
- R5: While requests remain, mem_req_valid stays high. One request is taken on each cycle with mem_req_ready high. While ready is low, the address and the write data hold steady.
- R6: mem_req_write is 1 for a store and 0 for a load. For a wide store, the write data of request k is source bits [64k+63:64k]. For a narrow store, it is bits [32k+31:32k] in the low half, with the upper 32 bits zero.
- R7: Load response j, counted in arrival order, fills lane j. A wide lane takes the full 64-bit response. A narrow lane takes response bits [31:0] into result bits [32j+31:32j].
- R8: result_data changes only in the cycle where done is high for a load. It holds steady through stores, rejects and partial loads.
- R9: done is a one-cycle pulse. For a store it comes in the cycle after the last request is accepted. For a load it comes in the cycle after the last response is taken.
- R10: cmd_ready is low from acceptance through the done or illegal cycle, and high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_wide | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| cmd_stride | input | STRIDE_W | Stride in elements |
| cmd_base | input | ADDR_W | Base byte address |
| cmd_src | input | VEC_W | Source vector for stores |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | Request is a write |
| mem_req_wide | output | 1 | Request is an 8-byte access (else 4-byte) |
| mem_req_addr | output | ADDR_W | Element byte address |
| mem_req_wdata | output | WORD_W | Write data |
| mem_rsp_valid | input | 1 | Load response present |
| mem_rsp_data | input | WORD_W | Load response data |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-stride pulse |
| result_data | output | VEC_W | Assembled load vector |

## Verification
The bench covers every stride from 2 to 7 in both element sizes and both directions, under three patterns of memory backpressure. A design that dropped a handshake, or advanced its address while stalled, would show a request with the wrong address or a missing lane. Strides 0 and 1 are sent to catch a sequencer that touches memory on a rejected command. It would be seen as a stray mem_req_valid, or as an illegal pulse that never arrives. Each load is compared against its response timing and against the result register on every cycle. This catches a block that publishes lanes one by one, places narrow lanes at 64-bit spacing, or raises done one cycle early or late.

// File: rtl/stride_pkg.sv
package stride_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FIN,
        ST_REJECT
    } seq_state_t;
endpackage

// File: rtl/stride_ctrl.sv
module stride_ctrl
    import stride_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int LW         = 4,
    parameter int STRIDE_W   = 3,
    parameter int STRIDE_MIN = 2,
    parameter int STRIDE_MAX = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_store,
    input  logic                cmd_wide,
    input  logic [STRIDE_W-1:0] cmd_stride,
    input  logic                mem_req_ready,
    input  logic                mem_rsp_valid,
    output logic                cmd_ready,
    output logic                cmd_take,
    output logic                mem_req_valid,
    output logic                req_fire,
    output logic                rsp_fire,
    output logic                commit,
    output logic                store_q,
    output logic                wide_q,
    output logic                done,
    output logic                illegal,
    output logic [IDX_W-1:0]    req_idx,
    output logic [IDX_W-1:0]    rsp_idx
);
    localparam int LN = 2 * LW;

    seq_state_t state_q, state_d;
    logic [IDX_W-1:0] req_idx_q, rsp_idx_q, last_idx;
    logic legal, last_req, last_rsp, in_flight;

    assign legal     = (int'(cmd_stride) >= STRIDE_MIN) && (int'(cmd_stride) <= STRIDE_MAX);
    assign last_idx  = wide_q ? IDX_W'(LW - 1) : IDX_W'(LN - 1);
    assign last_req  = (req_idx_q == last_idx);
    assign last_rsp  = (rsp_idx_q == last_idx);
    assign in_flight = (state_q == ST_ISSUE) || (state_q == ST_DRAIN);
    assign cmd_take  = cmd_valid && cmd_ready && legal;
    assign req_fire  = mem_req_valid && mem_req_ready;
    assign rsp_fire  = mem_rsp_valid && in_flight && !store_q;
    assign commit    = rsp_fire && last_rsp;
    assign req_idx   = req_idx_q;
    assign rsp_idx   = rsp_idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = legal ? ST_ISSUE : ST_REJECT;
            ST_ISSUE:  if (req_fire && last_req) state_d = store_q ? ST_FIN : ST_DRAIN;
            ST_DRAIN:  if (commit) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cmd_ready     = 1'b0;
        mem_req_valid = 1'b0;
        done          = 1'b0;
        illegal       = 1'b0;
        unique case (state_q)
            ST_IDLE:   cmd_ready     = 1'b1;
            ST_ISSUE:  mem_req_valid = 1'b1;
            ST_DRAIN:  ;
            ST_FIN:    done          = 1'b1;
            ST_REJECT: illegal       = 1'b1;
            default:   ;
        endcase
    end

    // lane counters and latched command attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_idx_q <= '0;
            rsp_idx_q <= '0;
            store_q   <= 1'b0;
            wide_q    <= 1'b0;
        end else if (cmd_take) begin
            req_idx_q <= '0;
            rsp_idx_q <= '0;
            store_q   <= cmd_store;
            wide_q    <= cmd_wide;
        end else begin
            if (req_fire) req_idx_q <= req_idx_q + 1'b1;
            if (rsp_fire) rsp_idx_q <= rsp_idx_q + 1'b1;
        end
    end

    // R7: responses never overtake requests while draining
    assert_rsp_behind_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (rsp_idx_q < req_idx_q));

    // R3: on completion the request count equals the lane count
    assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |-> (req_idx_q == (wide_q ? IDX_W'(LW) : IDX_W'(LN))));
endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
    parameter int ADDR_W   = 48,
    parameter int STRIDE_W = 3,
    parameter int WORD_W   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   base,
    input  logic [STRIDE_W-1:0] stride,
    input  logic                wide,
    input  logic                advance,
    output logic [ADDR_W-1:0]   addr
);
    localparam int SH_WIDE   = $clog2(WORD_W / 8);
    localparam int SH_NARROW = SH_WIDE - 1;

    logic [ADDR_W-1:0] addr_q, step_q, step_d;

    assign step_d = wide ? (ADDR_W'(stride) << SH_WIDE) : (ADDR_W'(stride) << SH_NARROW);
    assign addr   = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (load) begin
            addr_q <= base;
            step_q <= step_d;
        end else if (advance) begin
            addr_q <= addr_q + step_q;
        end
    end
endmodule

// File: rtl/stride_lane_data.sv
module stride_lane_data #(
    parameter int VEC_W  = 256,
    parameter int WORD_W = 64,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_load,
    input  logic [VEC_W-1:0]  src_in,
    input  logic              wide,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              rsp_fire,
    input  logic [IDX_W-1:0]  rsp_idx,
    input  logic [WORD_W-1:0] rsp_data,
    input  logic              commit,
    output logic [WORD_W-1:0] wdata,
    output logic [VEC_W-1:0]  result
);
    localparam int HALF = WORD_W / 2;
    localparam int NS   = VEC_W / HALF;
    localparam int SW   = $clog2(NS);

    logic [VEC_W-1:0] src_q, result_q, packed_d;
    logic [HALF-1:0]  src_slot [NS];
    logic [HALF-1:0]  buf_q    [NS];
    logic [HALF-1:0]  buf_d    [NS];
    logic [SW-1:0]    sel_lo, sel_hi;

    for (genvar s = 0; s < NS; s++) begin : g_slot
        logic hit;
        logic [HALF-1:0] incoming;
        assign src_slot[s] = src_q[s*HALF +: HALF];
        assign hit = rsp_fire && (wide ? (rsp_idx == IDX_W'(s / 2)) : (rsp_idx == IDX_W'(s)));
        if (s % 2 == 1) begin : g_odd
            assign incoming = wide ? rsp_data[WORD_W-1:HALF] : rsp_data[HALF-1:0];
        end else begin : g_even
            assign incoming = rsp_data[HALF-1:0];
        end
        assign buf_d[s] = hit ? incoming : buf_q[s];
        assign packed_d[s*HALF +: HALF] = buf_d[s];
    end

    assign sel_lo = wide ? {req_idx[SW-2:0], 1'b0} : req_idx[SW-1:0];
    assign sel_hi = {req_idx[SW-2:0], 1'b1};
    assign wdata  = wide ? {src_slot[sel_hi], src_slot[sel_lo]}
                         : {{HALF{1'b0}}, src_slot[sel_lo]};
    assign result = result_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            result_q <= '0;
            for (int s = 0; s < NS; s++) buf_q[s] <= '0;
        end else begin
            if (src_load) src_q <= src_in;
            for (int s = 0; s < NS; s++) buf_q[s] <= buf_d[s];
            if (commit) result_q <= packed_d;
        end
    end
endmodule

// File: rtl/stride_seq.sv
module stride_seq
    import stride_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int VEC_W      = 256,
    parameter int WORD_W     = 64,
    parameter int STRIDE_W   = 3,
    parameter int STRIDE_MIN = 2,
    parameter int STRIDE_MAX = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic                cmd_store,
    input  logic                cmd_wide,
    input  logic [STRIDE_W-1:0] cmd_stride,
    input  logic [ADDR_W-1:0]   cmd_base,
    input  logic [VEC_W-1:0]    cmd_src,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic                mem_req_wide,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [WORD_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data,
    output logic                done,
    output logic                illegal,
    output logic [VEC_W-1:0]    result_data
);
    localparam int LW    = VEC_W / WORD_W;
    localparam int IDX_W = $clog2(2 * LW + 1);

    logic cmd_take, req_fire, rsp_fire, commit, store_q, wide_q;
    logic [IDX_W-1:0] req_idx, rsp_idx;

    stride_ctrl #(
        .IDX_W(IDX_W), .LW(LW), .STRIDE_W(STRIDE_W),
        .STRIDE_MIN(STRIDE_MIN), .STRIDE_MAX(STRIDE_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_wide(cmd_wide),
        .cmd_stride(cmd_stride), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .cmd_ready(cmd_ready), .cmd_take(cmd_take),
        .mem_req_valid(mem_req_valid), .req_fire(req_fire), .rsp_fire(rsp_fire),
        .commit(commit), .store_q(store_q), .wide_q(wide_q), .done(done),
        .illegal(illegal), .req_idx(req_idx), .rsp_idx(rsp_idx)
    );

    stride_addr_gen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .WORD_W(WORD_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(cmd_take), .base(cmd_base),
        .stride(cmd_stride), .wide(cmd_wide), .advance(req_fire), .addr(mem_req_addr)
    );

    stride_lane_data #(.VEC_W(VEC_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .src_load(cmd_take), .src_in(cmd_src),
        .wide(wide_q), .req_idx(req_idx), .rsp_fire(rsp_fire), .rsp_idx(rsp_idx),
        .rsp_data(mem_rsp_data), .commit(commit), .wdata(mem_req_wdata),
        .result(result_data)
    );

    assign mem_req_write = store_q;
    assign mem_req_wide  = wide_q;

    // R2: a rejected stride leads to an illegal pulse and no request
    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && ((int'(cmd_stride) < STRIDE_MIN) || (int'(cmd_stride) > STRIDE_MAX)))
        |=> (illegal && !mem_req_valid));

    // R4: the first request goes to the base address
    assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (int'(cmd_stride) >= STRIDE_MIN) && (int'(cmd_stride) <= STRIDE_MAX))
        |=> (mem_req_valid && mem_req_addr == $past(cmd_base)));

    // R5: a stalled request holds its address and data
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    // R8: the result moves only in a done cycle
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result_data));

    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: the sequencer is ready again right after completion
    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || illegal) |=> cmd_ready);
endmodule

// File: tb/stride_seq_bench.sv
module stride_seq_bench;
    localparam int ADDR_W = 48;
    localparam int VEC_W  = 256;
    localparam int WORD_W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_store = 1'b0, cmd_wide = 1'b0;
    logic [2:0] cmd_stride = '0;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [VEC_W-1:0] cmd_src = '0;
    logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;
    logic cmd_ready, mem_req_valid, mem_req_write, mem_req_wide, done, illegal;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [WORD_W-1:0] mem_req_wdata;
    logic [VEC_W-1:0] result_data;

    always #5 clk = ~clk;

    stride_seq u_stride_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_store(cmd_store), .cmd_wide(cmd_wide), .cmd_stride(cmd_stride),
        .cmd_base(cmd_base), .cmd_src(cmd_src), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_wide(mem_req_wide), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .illegal(illegal),
        .result_data(result_data)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a[31:0] ^ 32'hC3D2_E1F0, ~a[31:0]};
    endfunction

    // reference model state
    logic [ADDR_W-1:0] exp_addr_q[$];
    logic [WORD_W-1:0] exp_wdata_q[$];
    logic [ADDR_W-1:0] pend_q[$];
    logic [VEC_W-1:0] m_result = '0, m_next_result = '0;
    bit m_busy = 0, m_exp_done = 0, m_exp_ill = 0, m_store = 0, m_wide = 0;
    int rsp_left = 0;
    int ready_mode = 0;
    bit acc_flag = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_done, exp_ill;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            exp_done = m_exp_done;
            exp_ill  = m_exp_ill;
            m_exp_done = 0;
            m_exp_ill  = 0;
            chk(cmd_ready == !m_busy, "R10 cmd_ready", VEC_W'(cmd_ready), VEC_W'(!m_busy));
            chk(done == exp_done, "R9 done timing", VEC_W'(done), VEC_W'(exp_done));
            chk(illegal == exp_ill, "R2 illegal pulse", VEC_W'(illegal), VEC_W'(exp_ill));
            if (exp_done || exp_ill) m_busy = 0;
            if (exp_done && !m_store) m_result = m_next_result;
            chk(result_data == m_result, "R8/R7 result", result_data, m_result);
            chk(mem_req_valid == (exp_addr_q.size() > 0), "R3/R5 req valid",
                VEC_W'(mem_req_valid), VEC_W'(exp_addr_q.size() > 0));
            // responses for requests accepted at earlier edges
            mem_rsp_valid = 1'b0;
            if (pend_q.size() > 0 && lfsr[5]) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_q.pop_front());
                rsp_left--;
                if (rsp_left == 0) m_exp_done = 1;
            end else begin
                mem_rsp_data = {lfsr, lfsr, lfsr, lfsr};
            end
            // backpressure
            case (ready_mode)
                0:       mem_req_ready = 1'b1;
                1:       mem_req_ready = lfsr[0] | lfsr[3];
                default: mem_req_ready = (lfsr[2:0] == 3'd0);
            endcase
            if (mem_req_valid && exp_addr_q.size() > 0) begin
                chk(mem_req_addr == exp_addr_q[0], "R4 address", VEC_W'(mem_req_addr), VEC_W'(exp_addr_q[0]));
                chk(mem_req_write == m_store, "R6 write flag", VEC_W'(mem_req_write), VEC_W'(m_store));
                chk(mem_req_wide == m_wide, "R3 size flag", VEC_W'(mem_req_wide), VEC_W'(m_wide));
                if (m_store)
                    chk(mem_req_wdata == exp_wdata_q[0], "R6 write data",
                        VEC_W'(mem_req_wdata), VEC_W'(exp_wdata_q[0]));
                if (mem_req_ready) begin
                    if (!m_store) pend_q.push_back(exp_addr_q[0]);
                    void'(exp_addr_q.pop_front());
                    void'(exp_wdata_q.pop_front());
                    if (m_store && exp_addr_q.size() == 0) m_exp_done = 1;
                end
            end
            // command acceptance
            if (cmd_valid && cmd_ready) begin
                acc_flag = 1;
                m_busy = 1;
                if (cmd_stride < 3'd2) begin
                    m_exp_ill = 1;
                end else begin
                    int lanes;
                    int bytes;
                    m_store = cmd_store;
                    m_wide  = cmd_wide;
                    lanes = cmd_wide ? 4 : 8;
                    bytes = cmd_wide ? 8 : 4;
                    rsp_left = cmd_store ? 0 : lanes;
                    m_next_result = '0;
                    for (int k = 0; k < lanes; k++) begin
                        logic [ADDR_W-1:0] a;
                        logic [WORD_W-1:0] w;
                        a = cmd_base + ADDR_W'(k * int'(cmd_stride) * bytes);
                        exp_addr_q.push_back(a);
                        if (cmd_wide) begin
                            w = cmd_src[k*64 +: 64];
                            m_next_result[k*64 +: 64] = mem_word(a);
                        end else begin
                            w = {32'h0, cmd_src[k*32 +: 32]};
                            m_next_result[k*32 +: 32] = mem_word(a)[31:0];
                        end
                        exp_wdata_q.push_back(w);
                    end
                end
            end
        end
    end

    task automatic run_cmd(input bit st, input bit wd, input logic [2:0] sd,
                           input logic [ADDR_W-1:0] base, input logic [VEC_W-1:0] src);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_store = st; cmd_wide = wd;
        cmd_stride = sd; cmd_base = base; cmd_src = src;
        do begin @(negedge clk); #1; end while (!acc_flag);
        acc_flag = 0;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
        cmd_src = ~cmd_src;
        cmd_base = ~cmd_base;
        do begin @(negedge clk); #1; end while (m_busy);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(cmd_ready == 1'b1, "R1 cmd_ready", VEC_W'(cmd_ready), VEC_W'(1));
        chk(mem_req_valid == 1'b0, "R1 req valid", VEC_W'(mem_req_valid), '0);
        chk(done == 1'b0 && illegal == 1'b0, "R1 pulses", VEC_W'({done, illegal}), '0);
        chk(result_data == '0, "R1 result", result_data, '0);
        rst_n = 1'b1;
        // directed cases: R4 wide and narrow loads, R6 stores, R2 rejects
        run_cmd(0, 1, 3'd2, 48'h0000_1000_0000, '0);
        run_cmd(0, 0, 3'd7, 48'hFFFF_FFFF_FF00, '0);
        run_cmd(1, 1, 3'd3, 48'h0000_0000_2040, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888,
                                                 64'h9999_AAAA_BBBB_CCCC, 64'hDDDD_EEEE_FFFF_0123});
        run_cmd(1, 0, 3'd5, 48'h0000_00AB_0004, {8{32'hF00D_0000}} ^ {32'd7, 32'd6, 32'd5, 32'd4,
                                                                     32'd3, 32'd2, 32'd1, 32'd0});
        run_cmd(0, 1, 3'd0, 48'h0000_0000_0100, '0);
        run_cmd(1, 0, 3'd1, 48'h0000_0000_0200, {8{32'hDEAD_BEEF}});
        // sweep of strides, sizes and directions under three backpressure patterns
        for (int mode = 0; mode < 3; mode++) begin
            ready_mode = mode;
            for (int sd = 2; sd <= 7; sd++) begin
                for (int wd = 0; wd < 2; wd++) begin
                    for (int st = 0; st < 2; st++) begin
                        logic [VEC_W-1:0] src;
                        for (int b = 0; b < 8; b++)
                            src[b*32 +: 32] = 32'h0102_0304 * (b + 1) + 32'(sd * 97 + mode);
                        run_cmd(st[0], wd[0], 3'(sd), 48'h0000_0300_0000 + 48'(sd * 4096 + mode * 64), src);
                    end
                end
            end
            run_cmd(0, 0, 3'd1, 48'h0, '0);
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule